// File: doc/BRIEF.md
# PLL Reset, Calibration and Holdover Sequencer

This block is the control state machine of a clock-multiplier PLL. It takes the PLL through reset, a wait for a valid reference, one self-calibration run, and then steady operation. Steady operation is either tracking the reference or digital hold. The analog core, the oscillator and the loop arithmetic sit outside. They receive a calibration start strobe, a freeze command for the oscillator control word and a phase build-out enable, and they report completion with a one-cycle done pulse.

The reset/calibrate pin is active low and asynchronous. The block synchronizes it and detects its rising edge with registers. Both a power-on reset and a rising edge on the pin request a calibration. Calibration waits until the loss alarm is clear. A loss during calibration sends the block back to waiting.

After calibration, a loss of the reference puts the block in digital hold without recalibrating. When the reference returns, a timed phase build-out window opens, unless fixed-delay mode is selected.

Top module: `pll_seq_ctrl`

## Requirements
- R1: Within three clock edges of the pin going low, `status_oe` is 0 and every other output is 0. They stay 0 while the pin stays low.
- R2: A power-on reset, or a rising edge on the pin, moves the block to the waiting state. In that state `status_oe` is 1 and `clk_out_en` is 0. With the pin held high through power-on, this happens without any toggle of the pin.
- R3: In the waiting state, the first cycle in which `los_alarm` is 0 produces a `cal_start` pulse exactly one cycle wide. The pulse appears in the first calibration cycle.
- R4: `cal_active` is 1 from the `cal_start` cycle through the cycle in which `cal_done` is sampled high, and 0 afterwards.
- R5: `clk_out_en` is 0 while waiting and while calibrating. It is 1 in the locked and hold states.
- R6: `los_alarm` high during calibration ends calibration and returns the block to waiting. A new `cal_start` follows once the alarm clears.
- R7: `los_alarm` high in the locked state enters hold. In hold, `freeze_word` is 1 and the output clock stays enabled. Returning to locked issues no new `cal_start`.
- R8: `hold_active` is 1 only in the hold state, and only while `los_alarm` is 1.
- R9: On return from hold, `pbo_en` is 1 for exactly `PBO_CYCLES` cycles when `fixed_delay` is 0 at the moment of return. It stays 0 when `fixed_delay` is 1. A new loss clears it at once.
- R10: A `cal_done` pulse outside calibration has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| rstcal_n | input | 1 | Asynchronous active-low reset/calibrate pin |
| los_alarm | input | 1 | Loss-of-reference alarm, 1 = no valid input |
| cal_done | input | 1 | One-cycle calibration completion pulse |
| fixed_delay | input | 1 | 1 = re-lock with fixed phase, no build-out |
| status_oe | output | 1 | Drive enable for status outputs, 0 = tri-state |
| cal_active | output | 1 | Calibration in progress |
| hold_active | output | 1 | Digital hold in effect |
| clk_out_en | output | 1 | Output clock enable |
| cal_start | output | 1 | One-cycle calibration start strobe |
| freeze_word | output | 1 | Freeze the oscillator control word |
| pbo_en | output | 1 | Phase build-out window enable |

## Verification
The bench runs long random sweeps with several alarm densities. It compares every output, every cycle, against a cycle-level model built from the requirements. It also runs directed scenarios for the corners.

- **Loss during calibration.** A design that ignored it would enable the output clock on a bad reference.
- **Return from hold.** A design that recalibrated here would emit a second start strobe.
- **Fixed-delay sampling.** A design that got this wrong would open or skip the build-out window wrongly.
- **Stray done pulses in the locked state.** A design that obeyed them would jump states.
- **Power-on with the pin already high.** A design without the synthetic edge would sit in reset.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_WAIT  = 3'd1,
    ST_CAL   = 3'd2,
    ST_LOCK  = 3'd3,
    ST_HOLD  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/pll_seq_pin_sync.sv
module pll_seq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_level,
  output logic pin_rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  // Flops reset to 0: a pin already high at power-on yields a rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], pin_async};
      prev <= sh[STAGES-1];
    end
  end

  assign pin_level = sh[STAGES-1];
  assign pin_rise  = sh[STAGES-1] & ~prev;

  AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise) else $error("double rise"); // R2
endmodule

// File: rtl/pll_seq_pbo_timer.sv
module pll_seq_pbo_timer #(
  parameter int PBO_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic active
);
  localparam int CW = $clog2(PBO_CYCLES + 1);
  localparam logic [CW-1:0] LOADV = CW'(PBO_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clear)         cnt <= '0;
    else if (load)          cnt <= LOADV;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  AST_PBO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOADV) else $error("timer overrun"); // R9
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_level,
  input  logic       pin_rise,
  input  logic       los,
  input  logic       cal_done,
  input  logic       fixed_delay,
  output seq_state_t state,
  output logic       cal_start,
  output logic       timer_load,
  output logic       timer_clear
);
  seq_state_t nxt;
  logic       start_nxt;

  always_comb begin
    nxt         = state;
    start_nxt   = 1'b0;
    timer_load  = 1'b0;
    timer_clear = 1'b0;
    if (!pin_level) begin
      nxt         = ST_RESET;
      timer_clear = 1'b1;
    end else begin
      unique case (state)
        ST_RESET: if (pin_rise) nxt = ST_WAIT;
        ST_WAIT:  if (!los) begin
                    nxt       = ST_CAL;
                    start_nxt = 1'b1;
                  end
        ST_CAL:   if (los)           nxt = ST_WAIT;
                  else if (cal_done) nxt = ST_LOCK;
        ST_LOCK:  if (los) begin
                    nxt         = ST_HOLD;
                    timer_clear = 1'b1;
                  end
        ST_HOLD:  if (!los) begin
                    nxt        = ST_LOCK;
                    timer_load = !fixed_delay;
                  end
        default:  nxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RESET;
      cal_start <= 1'b0;
    end else begin
      state     <= nxt;
      cal_start <= start_nxt;
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start) else $error("start too wide"); // R3
  AST_START_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> state == ST_CAL) else $error("start outside cal"); // R4
  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_HOLD) |-> $past(los) && $past(state) == ST_LOCK)
    else $error("bad hold entry"); // R7
  AST_LOCK_FROM_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_LOCK) |-> $past(state) == ST_CAL || $past(state) == ST_HOLD)
    else $error("bad lock entry"); // R10
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PBO_CYCLES  = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic rstcal_n,
  input  logic los_alarm,
  input  logic cal_done,
  input  logic fixed_delay,
  output logic status_oe,
  output logic cal_active,
  output logic hold_active,
  output logic clk_out_en,
  output logic cal_start,
  output logic freeze_word,
  output logic pbo_en
);
  logic       pin_level, pin_rise;
  logic       t_load, t_clear, t_active;
  seq_state_t st;

  pll_seq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(por_n), .pin_async(rstcal_n),
    .pin_level(pin_level), .pin_rise(pin_rise)
  );

  pll_seq_fsm u_fsm (
    .clk(clk), .rst_n(por_n), .pin_level(pin_level), .pin_rise(pin_rise),
    .los(los_alarm), .cal_done(cal_done), .fixed_delay(fixed_delay),
    .state(st), .cal_start(cal_start), .timer_load(t_load), .timer_clear(t_clear)
  );

  pll_seq_pbo_timer #(.PBO_CYCLES(PBO_CYCLES)) u_pbo (
    .clk(clk), .rst_n(por_n), .load(t_load), .clear(t_clear), .active(t_active)
  );

  assign status_oe   = (st != ST_RESET);
  assign cal_active  = (st == ST_CAL);
  assign clk_out_en  = (st == ST_LOCK) || (st == ST_HOLD);
  assign freeze_word = (st == ST_HOLD);
  assign hold_active = (st == ST_HOLD) && los_alarm;
  assign pbo_en      = t_active;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    !status_oe |-> !clk_out_en && !cal_active && !pbo_en && !cal_start)
    else $error("outputs live in reset"); // R1
  AST_CAL_NO_CLK: assert property (@(posedge clk) disable iff (!por_n)
    cal_active |-> !clk_out_en) else $error("clock during cal"); // R5
  AST_HOLD_LOS: assert property (@(posedge clk) disable iff (!por_n)
    hold_active |-> freeze_word && clk_out_en) else $error("hold w/o freeze"); // R8
  AST_PBO_START: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pbo_en) |-> $past(freeze_word) && !$past(fixed_delay))
    else $error("pbo w/o recovery"); // R9
endmodule

// File: tb/tb_pll_seq_ctrl.sv
module tb_pll_seq_ctrl;
  localparam int PBO = 16;

  logic clk = 1'b0;
  logic por_n, rstcal_n, los_alarm, cal_done, fixed_delay;
  logic status_oe, cal_active, hold_active, clk_out_en, cal_start, freeze_word, pbo_en;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pll_seq_ctrl #(.SYNC_STAGES(2), .PBO_CYCLES(PBO)) dut (
    .clk(clk), .por_n(por_n), .rstcal_n(rstcal_n), .los_alarm(los_alarm),
    .cal_done(cal_done), .fixed_delay(fixed_delay), .status_oe(status_oe),
    .cal_active(cal_active), .hold_active(hold_active), .clk_out_en(clk_out_en),
    .cal_start(cal_start), .freeze_word(freeze_word), .pbo_en(pbo_en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cycles, act, exp);
    end
  endtask

  // Reference model. States: 0 reset, 1 wait, 2 cal, 3 lock, 4 hold.
  logic m1, m2, m3, mstart;
  int   mst, mcnt;
  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m1 <= 0; m2 <= 0; m3 <= 0; mstart <= 0; mst <= 0; mcnt <= 0;
    end else begin
      m1 <= rstcal_n; m2 <= m1; m3 <= m2;
      mstart <= 0;
      if (mcnt != 0) mcnt <= mcnt - 1;
      if (!m2) begin
        mst <= 0; mcnt <= 0;
      end else begin
        case (mst)
          0: if (m2 && !m3) mst <= 1;
          1: if (!los_alarm) begin mst <= 2; mstart <= 1; end
          2: if (los_alarm) mst <= 1; else if (cal_done) mst <= 3;
          3: if (los_alarm) begin mst <= 4; mcnt <= 0; end
          4: if (!los_alarm) begin mst <= 3; mcnt <= fixed_delay ? 0 : PBO; end
          default: mst <= 0;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    #5;
    if (por_n && !done) begin
      chk("R1 status_oe",   status_oe,   mst != 0);
      chk("R3 cal_start",   cal_start,   mstart);
      chk("R4 cal_active",  cal_active,  mst == 2);
      chk("R5 clk_out_en",  clk_out_en,  mst >= 3);
      chk("R7 freeze_word", freeze_word, mst == 4);
      chk("R8 hold_active", hold_active, (mst == 4) && los_alarm);
      chk("R9 pbo_en",      pbo_en,      mcnt != 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    cal_done = 1; tick(1); cal_done = 0;
  endtask

  initial begin
    por_n = 0; rstcal_n = 1; los_alarm = 1; cal_done = 0; fixed_delay = 0;
    tick(3);
    chk("R1 reset state oe", status_oe, 1'b0);
    por_n = 1;
    tick(4);
    // R2: power-on with pin high reaches waiting state
    chk("R2 power-on wait oe", status_oe, 1'b1);
    chk("R2 power-on wait clk", clk_out_en, 1'b0);
    // pin low -> reset, pin high -> wait again
    rstcal_n = 0; tick(4);
    chk("R1 pin low oe", status_oe, 1'b0);
    rstcal_n = 1; tick(4);
    chk("R2 pin rise wait", status_oe, 1'b1);
    // R6: loss during calibration aborts
    los_alarm = 0; tick(2);
    chk("R6 cal running", cal_active, 1'b1);
    los_alarm = 1; tick(2);
    chk("R6 abort cal", cal_active, 1'b0);
    chk("R6 abort no clk", clk_out_en, 1'b0);
    los_alarm = 0; tick(1);
    chk("R6 restart strobe", cal_start, 1'b1);
    tick(2); pulse_done(); tick(1);
    chk("R5 locked clk", clk_out_en, 1'b1);
    // R10: stray done in lock
    pulse_done(); tick(2);
    chk("R10 stray done clk", clk_out_en, 1'b1);
    chk("R10 stray done cal", cal_active, 1'b0);
    // R7: hold and recovery without recal
    los_alarm = 1; tick(2);
    chk("R7 hold freeze", freeze_word, 1'b1);
    fixed_delay = 1; los_alarm = 0; tick(1);
    chk("R7 no recal", cal_start, 1'b0);
    chk("R9 fixed delay no pbo", pbo_en, 1'b0);
    fixed_delay = 0; los_alarm = 1; tick(2); los_alarm = 0; tick(1);
    chk("R9 pbo open", pbo_en, 1'b1);
    tick(PBO);
    chk("R9 pbo closed", pbo_en, 1'b0);

    // Random sweeps with varying alarm density
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 3000; i++) begin
        int r;
        r = $urandom % 1000;
        if (r < 3) rstcal_n = ~rstcal_n;
        else if (!rstcal_n && r < 60) rstcal_n = 1;
        if (($urandom % (4 + 8 * ph)) == 0) los_alarm = ~los_alarm;
        cal_done = (($urandom % 8) == 0);
        fixed_delay = (($urandom % 3) == 0);
        tick(1);
      end
    end
    cal_done = 0;
    tick(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule